// File: doc/BRIEF.md
# Pipeline Hazard Resolution Unit

This block holds the hazard-resolution logic for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). The pipeline resolves branch-equal and jump-register in the decode stage. The block looks at the register numbers read by the instructions in decode and execute. It also looks at the destination register, write-enable and load flags of the instructions in the execute, memory and writeback stages. From these it drives the forwarding multiplexer selects, a hold for the PC and the fetch/decode register, a bubble into the decode/execute register, and a flush of the fetch/decode register.

The unit is purely combinational. Every output is a function of the pipeline state presented in the same cycle. A multi-cycle stall arises because the held instruction sees the producer move down the pipeline one stage per cycle. The hold stays asserted until the value can be forwarded. Branches are predicted not taken and there is no delay slot. Jumps, jump-register and taken branches discard the one instruction already fetched behind them.

The register file is assumed to write in the first half of the cycle and read in the second. For that reason, a value in writeback reaches decode without a forwarding path.

Top module: `hazard_unit`

## Requirements
- R1: Each execute-stage operand select (`ex_fwd_a` from `ex_rs`, `ex_fwd_b` from `ex_rt`) is 2'b10 when the memory-stage instruction writes that register and is not a load. Otherwise it is 2'b01 when the writeback-stage instruction writes that register. Otherwise it is 2'b00, which means the register-file value.
- R2: When both the memory stage and the writeback stage write the same source register, the memory-stage (younger) result is selected, giving 2'b10.
- R3: Register 0 never causes forwarding or a stall. No select is nonzero for a source of 0, and a producer whose destination is 0 is ignored.
- R4: A decode instruction that reads `id_rs` (`id_use_rs`=1) or reads `id_rt` as a non-store operand (`id_use_rt`=1, `id_is_store`=0) holds when the execute-stage instruction is a load writing that register. The hold lasts only while the load is in execute. A load in the memory stage causes no hold for such an instruction.
- R5: A store in decode whose data register (`id_rt`) is loaded by the execute-stage instruction does not hold, unless its base register also matches. `ex_fwd_st` follows the R1 rule on `ex_rt` when `ex_is_store`=1 and is 2'b00 otherwise. `mem_fwd_st` is 1 when the memory-stage store's data register equals the nonzero destination of a load in writeback.
- R6: `id_fwd_a` is 1 when decode holds a branch-equal or jump-register and the memory-stage non-load instruction writes `id_rs`. `id_fwd_b` is 1 under the same producer condition on `id_rt` for a branch-equal only.
- R7: A branch-equal (operands `id_rs`, `id_rt`) or jump-register (operand `id_rs`) holds while the execute-stage instruction writes one of its operands, whether that instruction is a load or not.
- R8: A branch-equal or jump-register holds while a load in the memory stage writes one of its operands. A load directly ahead therefore costs two hold cycles, and a load one instruction ahead costs one.
- R9: `flush` is 1 for a jump, a jump-register, or a branch-equal with `id_br_eq`=1, and 0 for a branch-equal with `id_br_eq`=0.
- R10: `hold` and `bubble` are always equal, and `flush` is 0 whenever `hold` is 1.
- R11: A load in the memory stage is never a forwarding source for the execute operands or the decode comparison operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs | input | RW | first source register of the decode instruction |
| id_rt | input | RW | second source register of the decode instruction |
| id_use_rs | input | 1 | decode instruction reads id_rs |
| id_use_rt | input | 1 | decode instruction reads id_rt |
| id_is_beq | input | 1 | decode instruction is branch-equal |
| id_is_jr | input | 1 | decode instruction is jump-register |
| id_is_jump | input | 1 | decode instruction is an immediate jump or jump-and-link |
| id_is_store | input | 1 | decode instruction is a store |
| id_br_eq | input | 1 | decode comparison found the operands equal |
| ex_rs | input | RW | first source register in execute |
| ex_rt | input | RW | second source register in execute |
| ex_is_store | input | 1 | execute instruction is a store |
| ex_rd | input | RW | destination register in execute |
| ex_wr | input | 1 | execute instruction writes a register |
| ex_ld | input | 1 | execute instruction is a load |
| mem_rd | input | RW | destination register in memory stage |
| mem_wr | input | 1 | memory-stage instruction writes a register |
| mem_ld | input | 1 | memory-stage instruction is a load |
| mem_rt | input | RW | data register of the memory-stage instruction |
| mem_is_store | input | 1 | memory-stage instruction is a store |
| wb_rd | input | RW | destination register in writeback |
| wb_wr | input | 1 | writeback instruction writes a register |
| wb_ld | input | 1 | writeback instruction is a load |
| ex_fwd_a | output | 2 | execute operand A select |
| ex_fwd_b | output | 2 | execute operand B select |
| ex_fwd_st | output | 2 | execute store-data select |
| mem_fwd_st | output | 1 | memory-stage store data taken from writeback load |
| id_fwd_a | output | 1 | decode comparison operand A from memory-stage result |
| id_fwd_b | output | 1 | decode comparison operand B from memory-stage result |
| hold | output | 1 | freeze PC and fetch/decode register |
| bubble | output | 1 | load a no-op into decode/execute register |
| flush | output | 1 | clear fetch/decode register |

## Verification
Every output is combinational and is due in the same cycle in which the pipeline state is presented. There is no register between the inputs and any select or control. The bench therefore drives each state on the falling clock edge and samples two nanoseconds later, well before the next rising edge. The two-cycle and one-cycle stall cases are checked as successive cycles. In each cycle the bench advances the producer one stage and checks that the hold is still present or has gone.

// File: rtl/hz_pkg.sv
`timescale 1ns/1ps
// Shared types for the hazard unit.
// Assumes the datapath forwarding muxes decode the select with the
// encoding below: register file, writeback result, memory-stage result.
package hz_pkg;
    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_WB  = 2'b01,
        FWD_MEM = 2'b10
    } fwd_sel_e;
endpackage

// File: rtl/hz_ex_fwd.sv
`timescale 1ns/1ps
// Execute-stage forwarding selects for N_OPS source operands.
// Assumes a load's memory-stage result is an address, never a value,
// so loads there are excluded; the memory stage beats writeback.
module hz_ex_fwd #(
    parameter int RW    = 5,
    parameter int N_OPS = 2
) (
    input  logic [N_OPS-1:0][RW-1:0]        src_reg,
    input  logic [RW-1:0]                   mem_dst,
    input  logic                            mem_wen,
    input  logic                            mem_load,
    input  logic [RW-1:0]                   wb_dst,
    input  logic                            wb_wen,
    output hz_pkg::fwd_sel_e [N_OPS-1:0]    sel
);
    localparam logic [RW-1:0] ZERO_REG = '0;

    logic mem_src_ok;
    logic wb_src_ok;

    // Qualify each producer stage once for all operands.
    assign mem_src_ok = mem_wen && !mem_load && (mem_dst != ZERO_REG);
    assign wb_src_ok  = wb_wen && (wb_dst != ZERO_REG);

    // One priority select per operand, younger producer first.
    for (genvar g = 0; g < N_OPS; g++) begin : g_op
        assign sel[g] = (mem_src_ok && (src_reg[g] == mem_dst)) ? hz_pkg::FWD_MEM :
                        (wb_src_ok  && (src_reg[g] == wb_dst))  ? hz_pkg::FWD_WB  :
                                                                  hz_pkg::FWD_RF;
    end
endmodule

// File: rtl/hz_id_fwd.sv
`timescale 1ns/1ps
// Decode-stage comparison forwarding from the memory-stage result.
// Assumes writeback reaches decode through the register-file bypass,
// so only the memory stage needs a path; operand 1 is branch-only.
module hz_id_fwd #(
    parameter int RW = 5
) (
    input  logic [RW-1:0] id_rs,
    input  logic [RW-1:0] id_rt,
    input  logic          is_beq,
    input  logic          is_jr,
    input  logic [RW-1:0] mem_dst,
    input  logic          mem_wen,
    input  logic          mem_load,
    output logic          fwd_rs,
    output logic          fwd_rt
);
    localparam int       N_CMP    = 2;
    localparam logic [RW-1:0] ZERO_REG = '0;

    logic [N_CMP-1:0][RW-1:0] cmp_reg;
    logic [N_CMP-1:0]         cmp_used;
    logic [N_CMP-1:0]         cmp_fwd;
    logic                     mem_ok;

    // Gather operands and which control-flow class reads each one.
    assign cmp_reg  = {id_rt, id_rs};
    assign cmp_used = {is_beq, is_beq || is_jr};
    assign mem_ok   = mem_wen && !mem_load && (mem_dst != ZERO_REG);

    // Per-operand match against the memory-stage ALU result.
    for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
        assign cmp_fwd[g] = cmp_used[g] && mem_ok && (cmp_reg[g] == mem_dst);
    end

    assign fwd_rs = cmp_fwd[0];
    assign fwd_rt = cmp_fwd[1];
endmodule

// File: rtl/hz_stall.sv
`timescale 1ns/1ps
// Stall detection for the decode instruction.
// Load-use: producer load in execute, consumer operand read in execute.
// Control-flow: operand needed in decode, so any execute producer, or a
// load still in the memory stage, forces a wait. A store's data operand
// is exempt from load-use because it is patched later in the memory stage.
module hz_stall #(
    parameter int RW = 5
) (
    input  logic [RW-1:0] id_rs,
    input  logic [RW-1:0] id_rt,
    input  logic          use_rs,
    input  logic          use_rt,
    input  logic          is_store,
    input  logic          is_beq,
    input  logic          is_jr,
    input  logic [RW-1:0] ex_dst,
    input  logic          ex_wen,
    input  logic          ex_load,
    input  logic [RW-1:0] mem_dst,
    input  logic          mem_wen,
    input  logic          mem_load,
    output logic          stall
);
    localparam logic [RW-1:0] ZERO_REG = '0;

    logic ex_live, mem_load_live;
    logic rs_ex, rt_ex, rs_mem, rt_mem;
    logic load_use, cf_rs, cf_rt, cf_wait;

    // Producer qualifiers: nonzero destination with write enabled.
    assign ex_live       = ex_wen && (ex_dst != ZERO_REG);
    assign mem_load_live = mem_wen && mem_load && (mem_dst != ZERO_REG);

    // Register matches against each producer.
    assign rs_ex  = ex_live && (id_rs == ex_dst);
    assign rt_ex  = ex_live && (id_rt == ex_dst);
    assign rs_mem = mem_load_live && (id_rs == mem_dst);
    assign rt_mem = mem_load_live && (id_rt == mem_dst);

    // Load-use for operands consumed in execute.
    assign load_use = ex_load && ((use_rs && rs_ex) || (use_rt && !is_store && rt_ex));

    // Operands consumed in decode by branch-equal or jump-register.
    assign cf_rs   = (is_beq || is_jr) && (rs_ex || rs_mem);
    assign cf_rt   = is_beq && (rt_ex || rt_mem);
    assign cf_wait = cf_rs || cf_rt;

    assign stall = load_use || cf_wait;
endmodule

// File: rtl/hz_redirect.sv
`timescale 1ns/1ps
// Pipeline-register control from the stall decision and redirects.
// Assumes predict-not-taken with no delay slot: one fetched instruction
// is discarded on a redirect, and a stalled redirect waits its turn.
module hz_redirect (
    input  logic stall,
    input  logic is_jump,
    input  logic is_jr,
    input  logic is_beq,
    input  logic br_eq,
    output logic hold,
    output logic bubble,
    output logic flush
);
    logic redirect;

    // A redirect happens on any jump or an equal branch.
    assign redirect = is_jump || is_jr || (is_beq && br_eq);

    // Stall freezes fetch/decode and injects a no-op behind it.
    assign hold   = stall;
    assign bubble = stall;

    // Discard the wrong-path fetch only once the redirect proceeds.
    assign flush  = redirect && !stall;
endmodule

// File: rtl/hazard_unit.sv
`timescale 1ns/1ps
// Top of the hazard unit: forwarding selects, store-data patching,
// stall, bubble and flush for a five-stage pipeline with decode-stage
// branch resolution. Purely combinational; assumes a register file with
// write-before-read bypass.
module hazard_unit #(
    parameter int RW = 5
) (
    input  logic [RW-1:0] id_rs,
    input  logic [RW-1:0] id_rt,
    input  logic          id_use_rs,
    input  logic          id_use_rt,
    input  logic          id_is_beq,
    input  logic          id_is_jr,
    input  logic          id_is_jump,
    input  logic          id_is_store,
    input  logic          id_br_eq,
    input  logic [RW-1:0] ex_rs,
    input  logic [RW-1:0] ex_rt,
    input  logic          ex_is_store,
    input  logic [RW-1:0] ex_rd,
    input  logic          ex_wr,
    input  logic          ex_ld,
    input  logic [RW-1:0] mem_rd,
    input  logic          mem_wr,
    input  logic          mem_ld,
    input  logic [RW-1:0] mem_rt,
    input  logic          mem_is_store,
    input  logic [RW-1:0] wb_rd,
    input  logic          wb_wr,
    input  logic          wb_ld,
    output logic [1:0]    ex_fwd_a,
    output logic [1:0]    ex_fwd_b,
    output logic [1:0]    ex_fwd_st,
    output logic          mem_fwd_st,
    output logic          id_fwd_a,
    output logic          id_fwd_b,
    output logic          hold,
    output logic          bubble,
    output logic          flush
);
    localparam int            N_EX_OPS = 2;
    localparam logic [RW-1:0] ZERO_REG = '0;

    logic [N_EX_OPS-1:0][RW-1:0]         ex_src;
    hz_pkg::fwd_sel_e [N_EX_OPS-1:0]     ex_sel;
    logic                                stall;

    // Execute operand sources in select order.
    assign ex_src = {ex_rt, ex_rs};

    hz_ex_fwd #(.RW(RW), .N_OPS(N_EX_OPS)) u_ex_fwd (
        .src_reg  (ex_src),
        .mem_dst  (mem_rd),
        .mem_wen  (mem_wr),
        .mem_load (mem_ld),
        .wb_dst   (wb_rd),
        .wb_wen   (wb_wr),
        .sel      (ex_sel)
    );

    // Operand selects, and store data only for a store in execute.
    assign ex_fwd_a  = ex_sel[0];
    assign ex_fwd_b  = ex_sel[1];
    assign ex_fwd_st = ex_is_store ? ex_sel[1] : hz_pkg::FWD_RF;

    // Late store-data patch from a load that has just reached writeback.
    assign mem_fwd_st = mem_is_store && wb_wr && wb_ld &&
                        (wb_rd != ZERO_REG) && (wb_rd == mem_rt);

    hz_id_fwd #(.RW(RW)) u_id_fwd (
        .id_rs    (id_rs),
        .id_rt    (id_rt),
        .is_beq   (id_is_beq),
        .is_jr    (id_is_jr),
        .mem_dst  (mem_rd),
        .mem_wen  (mem_wr),
        .mem_load (mem_ld),
        .fwd_rs   (id_fwd_a),
        .fwd_rt   (id_fwd_b)
    );

    hz_stall #(.RW(RW)) u_stall (
        .id_rs    (id_rs),
        .id_rt    (id_rt),
        .use_rs   (id_use_rs),
        .use_rt   (id_use_rt),
        .is_store (id_is_store),
        .is_beq   (id_is_beq),
        .is_jr    (id_is_jr),
        .ex_dst   (ex_rd),
        .ex_wen   (ex_wr),
        .ex_load  (ex_ld),
        .mem_dst  (mem_rd),
        .mem_wen  (mem_wr),
        .mem_load (mem_ld),
        .stall    (stall)
    );

    hz_redirect u_redirect (
        .stall   (stall),
        .is_jump (id_is_jump),
        .is_jr   (id_is_jr),
        .is_beq  (id_is_beq),
        .br_eq   (id_br_eq),
        .hold    (hold),
        .bubble  (bubble),
        .flush   (flush)
    );
endmodule

// File: rtl/hazard_unit_chk.sv
`timescale 1ns/1ps
// Checker for hazard_unit: relates the top-level selects and controls
// to the pipeline state. The block is combinational, so the checks are
// immediate assertions evaluated whenever the ports settle.
module hazard_unit_chk #(
    parameter int RW = 5
) (
    input logic [RW-1:0] id_rs,
    input logic [RW-1:0] id_rt,
    input logic          id_use_rs,
    input logic          id_use_rt,
    input logic          id_is_beq,
    input logic          id_is_jr,
    input logic          id_is_jump,
    input logic          id_is_store,
    input logic          id_br_eq,
    input logic [RW-1:0] ex_rs,
    input logic [RW-1:0] ex_rt,
    input logic          ex_is_store,
    input logic [RW-1:0] ex_rd,
    input logic          ex_wr,
    input logic          ex_ld,
    input logic [RW-1:0] mem_rd,
    input logic          mem_wr,
    input logic          mem_ld,
    input logic [RW-1:0] mem_rt,
    input logic          mem_is_store,
    input logic [RW-1:0] wb_rd,
    input logic          wb_wr,
    input logic          wb_ld,
    input logic [1:0]    ex_fwd_a,
    input logic [1:0]    ex_fwd_b,
    input logic [1:0]    ex_fwd_st,
    input logic          mem_fwd_st,
    input logic          id_fwd_a,
    input logic          id_fwd_b,
    input logic          hold,
    input logic          bubble,
    input logic          flush
);
    localparam logic [RW-1:0] Z = '0;

    // Evaluate all port relations after each settle.
    always_comb begin
        p_hold_bubble_r10: assert (hold == bubble)
            else $error("hold and bubble differ");
        p_stall_over_flush_r10: assert (!(hold && flush))
            else $error("flush during hold");
        p_zero_src_r3: assert ((ex_rs != Z || ex_fwd_a == 2'b00) &&
                               (ex_rt != Z || ex_fwd_b == 2'b00) &&
                               (id_rs != Z || !id_fwd_a) &&
                               (id_rt != Z || !id_fwd_b))
            else $error("forward for register 0");
        p_mem_load_src_r11: assert (!(mem_ld && (ex_fwd_a == 2'b10 || ex_fwd_b == 2'b10 ||
                                                 id_fwd_a || id_fwd_b)))
            else $error("memory-stage load used as source");
        p_younger_first_r2: assert (!(mem_wr && !mem_ld && mem_rd != Z && mem_rd == ex_rs &&
                                      wb_wr && wb_rd == ex_rs) || ex_fwd_a == 2'b10)
            else $error("older producer chosen");
        p_load_use_r4: assert (!(ex_ld && ex_wr && ex_rd != Z && id_use_rs && id_rs == ex_rd) || hold)
            else $error("missing load-use hold");
        p_store_data_no_hold_r5: assert (!(id_is_store && !id_is_beq && !id_is_jr &&
                                           ex_ld && ex_wr && ex_rd != Z &&
                                           id_rt == ex_rd && id_rs != ex_rd) || !hold)
            else $error("store data load caused hold");
        p_cf_alu_hold_r7: assert (!((id_is_beq || id_is_jr) && ex_wr && ex_rd != Z &&
                                    id_rs == ex_rd) || hold)
            else $error("missing control-flow hold");
        p_cf_load_mem_r8: assert (!(id_is_beq && mem_wr && mem_ld && mem_rd != Z &&
                                    id_rt == mem_rd) || hold)
            else $error("missing hold on load in memory stage");
        p_jump_flush_r9: assert (!(id_is_jump && !hold) || flush)
            else $error("jump without flush");
        p_store_sel_r5: assert (ex_is_store || ex_fwd_st == 2'b00)
            else $error("store select for non-store");
        p_late_store_r5: assert (!mem_fwd_st || (mem_is_store && wb_ld))
            else $error("late store patch without load");
    end
endmodule

bind hazard_unit hazard_unit_chk #(.RW(RW)) u_chk (.*);

// File: tb/hazard_unit_bench.sv
`timescale 1ns/1ps
// Self-checking bench: random pipeline states plus directed sequences,
// compared against a reference model written from the requirements.
module hazard_unit_bench;
    localparam int RW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [RW-1:0] id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, mem_rt, wb_rd;
    logic id_use_rs, id_use_rt, id_is_beq, id_is_jr, id_is_jump, id_is_store, id_br_eq;
    logic ex_is_store, ex_wr, ex_ld, mem_wr, mem_ld, mem_is_store, wb_wr, wb_ld;
    logic [1:0] ex_fwd_a, ex_fwd_b, ex_fwd_st;
    logic mem_fwd_st, id_fwd_a, id_fwd_b, hold, bubble, flush;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    hazard_unit #(.RW(RW)) u_hazard_unit (.*);

    // Reference: execute-stage select for one source register.
    function automatic logic [1:0] ref_ex(input logic [RW-1:0] s);
        if (s != 0 && mem_wr && !mem_ld && mem_rd == s) return 2'b10;
        if (s != 0 && wb_wr && wb_rd == s) return 2'b01;
        return 2'b00;
    endfunction

    // Reference: decode operand must wait for this register.
    function automatic logic ref_wait(input logic [RW-1:0] s);
        return s != 0 && ((ex_wr && ex_rd == s) || (mem_wr && mem_ld && mem_rd == s));
    endfunction

    function automatic logic ref_stall();
        logic lu, cf;
        lu = ex_ld && ex_wr && ex_rd != 0 &&
             ((id_use_rs && id_rs == ex_rd) || (id_use_rt && !id_is_store && id_rt == ex_rd));
        cf = ((id_is_beq || id_is_jr) && ref_wait(id_rs)) || (id_is_beq && ref_wait(id_rt));
        return lu || cf;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // Compare every output against the model, tagged by requirement.
    task automatic check_all();
        logic st, fl;
        st = ref_stall();
        fl = !st && (id_is_jump || id_is_jr || (id_is_beq && id_br_eq));
        chk("R1 ex_fwd_a", ex_fwd_a, ref_ex(ex_rs));
        chk("R1 ex_fwd_b", ex_fwd_b, ref_ex(ex_rt));
        chk("R5 ex_fwd_st", ex_fwd_st, ex_is_store ? ref_ex(ex_rt) : 2'b00);
        chk("R5 mem_fwd_st", mem_fwd_st,
            mem_is_store && wb_wr && wb_ld && wb_rd != 0 && wb_rd == mem_rt);
        chk("R6 id_fwd_a", id_fwd_a,
            (id_is_beq || id_is_jr) && id_rs != 0 && mem_wr && !mem_ld && mem_rd == id_rs);
        chk("R6 id_fwd_b", id_fwd_b,
            id_is_beq && id_rt != 0 && mem_wr && !mem_ld && mem_rd == id_rt);
        chk("R4/R7/R8 hold", hold, st);
        chk("R10 bubble", bubble, st);
        chk("R9 flush", flush, fl);
    endtask

    task automatic idle();
        {id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, mem_rt, wb_rd} = '0;
        {id_use_rs, id_use_rt, id_is_beq, id_is_jr, id_is_jump, id_is_store, id_br_eq} = '0;
        {ex_is_store, ex_wr, ex_ld, mem_wr, mem_ld, mem_is_store, wb_wr, wb_ld} = '0;
    endtask

    task automatic settle();
        #2;
    endtask

    // Watchdog: an expired run is a failed check.
    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        idle();
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk); settle();
        // Reset/idle state: nothing forwarded, no stall, no flush.
        chk("R1 idle ex_fwd_a", ex_fwd_a, 0);
        chk("R10 idle hold", hold, 0);
        chk("R9 idle flush", flush, 0);

        // R2: both stages write ex_rs, memory stage wins.
        @(negedge clk); idle();
        ex_rs = 5'd4; mem_rd = 5'd4; mem_wr = 1; wb_rd = 5'd4; wb_wr = 1;
        settle(); chk("R2 priority", ex_fwd_a, 2); check_all();

        // R3: producer to register 0 ignored.
        @(negedge clk); idle();
        mem_wr = 1; wb_wr = 1; ex_wr = 1; ex_ld = 1; id_use_rs = 1; id_is_beq = 1;
        settle(); chk("R3 zero fwd", ex_fwd_a, 0); chk("R3 zero hold", hold, 0); check_all();

        // R11: load in memory stage not forwarded to execute.
        @(negedge clk); idle();
        ex_rs = 5'd8; mem_rd = 5'd8; mem_wr = 1; mem_ld = 1; wb_rd = 5'd8; wb_wr = 1;
        settle(); chk("R11 load not src", ex_fwd_a, 1); check_all();

        // R4: load then consumer: one hold, then none.
        @(negedge clk); idle();
        id_rs = 5'd9; id_rt = 5'd8; id_use_rs = 1; id_use_rt = 1;
        ex_rd = 5'd8; ex_wr = 1; ex_ld = 1;
        settle(); chk("R4 load-use hold", hold, 1); check_all();
        @(negedge clk); ex_wr = 0; ex_ld = 0; mem_rd = 5'd8; mem_wr = 1; mem_ld = 1;
        settle(); chk("R4 one cycle only", hold, 0); check_all();

        // R5: store data from preceding load does not hold.
        @(negedge clk); idle();
        id_is_store = 1; id_use_rs = 1; id_use_rt = 1; id_rs = 5'd0; id_rt = 5'd4;
        ex_rd = 5'd4; ex_wr = 1; ex_ld = 1;
        settle(); chk("R5 store no hold", hold, 0); check_all();
        @(negedge clk); idle();
        mem_is_store = 1; mem_rt = 5'd4; wb_rd = 5'd4; wb_wr = 1; wb_ld = 1;
        settle(); chk("R5 late store fwd", mem_fwd_st, 1); check_all();

        // R7: branch right after ALU producer holds one cycle, then forwards.
        @(negedge clk); idle();
        id_is_beq = 1; id_rs = 5'd0; id_rt = 5'd4; id_br_eq = 1;
        ex_rd = 5'd4; ex_wr = 1;
        settle(); chk("R7 alu hold", hold, 1); chk("R10 no flush in hold", flush, 0);
        @(negedge clk); ex_wr = 0; mem_rd = 5'd4; mem_wr = 1;
        settle(); chk("R7 released", hold, 0); chk("R6 fwd b", id_fwd_b, 1);
        chk("R9 taken flush", flush, 1); check_all();

        // R8: jump-register right after load: two holds.
        @(negedge clk); idle();
        id_is_jr = 1; id_rs = 5'd10; ex_rd = 5'd10; ex_wr = 1; ex_ld = 1;
        settle(); chk("R8 load hold 1", hold, 1);
        @(negedge clk); ex_wr = 0; ex_ld = 0; mem_rd = 5'd10; mem_wr = 1; mem_ld = 1;
        settle(); chk("R8 load hold 2", hold, 1); check_all();
        @(negedge clk); mem_wr = 0; mem_ld = 0; wb_rd = 5'd10; wb_wr = 1; wb_ld = 1;
        settle(); chk("R8 load released", hold, 0); chk("R9 jr flush", flush, 1);

        // R9: untaken branch no flush.
        @(negedge clk); idle();
        id_is_beq = 1; id_rs = 5'd3; id_rt = 5'd2;
        settle(); chk("R9 untaken", flush, 0); check_all();

        // Random states over a narrow register range.
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            id_rs = RW'($urandom % 4); id_rt = RW'($urandom % 4);
            ex_rs = RW'($urandom % 4); ex_rt = RW'($urandom % 4);
            ex_rd = RW'($urandom % 4); mem_rd = RW'($urandom % 4);
            mem_rt = RW'($urandom % 4); wb_rd = RW'($urandom % 4);
            {id_use_rs, id_use_rt, id_br_eq, ex_is_store, ex_wr, ex_ld} = 6'($urandom);
            {mem_wr, mem_ld, mem_is_store, wb_wr, wb_ld} = 5'($urandom);
            {id_is_beq, id_is_jr, id_is_jump, id_is_store} = 4'b0;
            case ($urandom % 5)
                0: id_is_beq = 1;
                1: id_is_jr = 1;
                2: id_is_jump = 1;
                3: id_is_store = 1;
                default: ;
            endcase
            settle();
            check_all();
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule